// File: doc/BRIEF.md
# Breaker Failure Detection Logic

This block watches a protection scheme's failure-initiate request together with evidence that the breaker has not opened. It declares breaker failure when both conditions hold for longer than a programmable pickup time. The breaker counts as still closed when the phase current flag is set, or the ground current flag is set, or the auxiliary closed contact is set. The contact is used only when supervision is enabled.

A registered scheme term combines the initiate request with the closed-breaker evidence. When seal-in is enabled, the scheme term holds itself after the initiate request drops, for as long as the breaker still looks closed. A pickup counter advances once per power-cycle tick strobe while the scheme term is high, and clears on any clock where the term is low. The trip output is updated only on tick strobes, and the dropout delay is zero.

Top module: `bf_detect`

## Requirements
- R1: The scheme term becomes true when initiate is high and at least one of these holds: phaseCur is high, groundCur is high, or supervisionEn and closedContact are both high.
- R2: With supervisionEn low, closedContact has no effect. Initiate with only the contact set never produces a trip.
- R3: With sealInEn low, if initiate drops before pickup completes, no trip is declared.
- R4: With sealInEn high, the scheme term stays true after initiate drops while the closed-breaker evidence remains, so the trip still follows. The term releases once that evidence goes away.
- R5: With pickupCycles = N, failTrip rises on the (N+1)-th tick while the scheme term is continuously true. The tests use N = 10.
- R6: With pickupCycles = 0, failTrip rises on the first tick after the scheme term becomes true.
- R7: failTrip falls on the first tick on which the scheme term is false.
- R8: Any clock with the scheme term false clears the pickup count, so a brief interruption restarts the full pickup time.
- R9: A synchronous active-high rst clears the scheme term, the count and failTrip.
- R10: failTrip changes only in the clock after a cycleTick pulse (or on reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| initiate | input | 1 | Failure-initiate request |
| closedContact | input | 1 | Breaker auxiliary closed contact |
| phaseCur | input | 1 | Phase current present flag |
| groundCur | input | 1 | Ground current present flag |
| supervisionEn | input | 1 | Use the auxiliary contact as closed evidence |
| sealInEn | input | 1 | Latch the scheme term after initiate drops |
| cycleTick | input | 1 | One-clock strobe per power cycle |
| pickupCycles | input | 16 | Pickup delay in ticks |
| failTrip | output | 1 | Timed breaker-failure trip |

## Verification
The assertions assume that cycleTick is a single-clock pulse and that pickupCycles holds steady while a pickup is in progress. Without that, saturation of the count against a moving limit could not be reasoned about. The stimulus changes every input on the falling clock edge. Before each run of tick pulses, the bench lets the scheme term settle for two clocks. Tick pulses are spaced at least one idle clock apart, and the pickup setting changes only while the scheme term is low.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef struct packed {
    logic clearCount;
    logic incCount;
    logic loadTrip;
    logic tripValue;
  } bfStrobes_t;
endpackage

// File: rtl/bf_datapath.sv
module bf_datapath #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  bf_pkg::bfStrobes_t strobes,
  input  logic [CNT_W-1:0] pickupCycles,
  output logic             atPickup
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tickCount;

  always_ff @(posedge clk) begin
    if (rst || strobes.clearCount) begin
      tickCount <= '0;
    end else if (strobes.incCount && tickCount != CNT_MAX) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  assign atPickup = (tickCount >= pickupCycles);
endmodule

// File: rtl/bf_ctrl.sv
module bf_ctrl (
  input  logic               clk,
  input  logic               rst,
  input  logic               initiate,
  input  logic               closedContact,
  input  logic               phaseCur,
  input  logic               groundCur,
  input  logic               supervisionEn,
  input  logic               sealInEn,
  input  logic               cycleTick,
  input  logic               atPickup,
  output bf_pkg::bfStrobes_t strobes,
  output logic               schemeVar,
  output logic               failTrip
);
  logic breakerClosed;
  logic requestTerm;
  logic schemeNext;

  // Closed evidence: either current flag, or the contact when supervised.
  assign breakerClosed = phaseCur | groundCur | (supervisionEn & closedContact);
  assign requestTerm   = initiate | (sealInEn & schemeVar);
  assign schemeNext    = requestTerm & breakerClosed;

  always_ff @(posedge clk) begin
    if (rst) schemeVar <= 1'b0;
    else     schemeVar <= schemeNext;
  end

  always_comb begin
    strobes.clearCount = ~schemeVar;
    strobes.incCount   = cycleTick & schemeVar & ~atPickup;
    strobes.loadTrip   = cycleTick;
    strobes.tripValue  = schemeVar & atPickup;
  end

  always_ff @(posedge clk) begin
    if (rst)                   failTrip <= 1'b0;
    else if (strobes.loadTrip) failTrip <= strobes.tripValue;
  end
endmodule

// File: rtl/bf_detect.sv
module bf_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             initiate,
  input  logic             closedContact,
  input  logic             phaseCur,
  input  logic             groundCur,
  input  logic             supervisionEn,
  input  logic             sealInEn,
  input  logic             cycleTick,
  input  logic [CNT_W-1:0] pickupCycles,
  output logic             failTrip
);
  bf_pkg::bfStrobes_t strobes;
  logic atPickup;
  logic schemeVar;

  bf_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .initiate     (initiate),
    .closedContact(closedContact),
    .phaseCur     (phaseCur),
    .groundCur    (groundCur),
    .supervisionEn(supervisionEn),
    .sealInEn     (sealInEn),
    .cycleTick    (cycleTick),
    .atPickup     (atPickup),
    .strobes      (strobes),
    .schemeVar    (schemeVar),
    .failTrip     (failTrip)
  );

  bf_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .pickupCycles(pickupCycles),
    .atPickup    (atPickup)
  );
endmodule

// File: rtl/bf_detect_checker.sv
module bf_detect_checker (
  input logic clk,
  input logic rst,
  input logic initiate,
  input logic closedContact,
  input logic phaseCur,
  input logic groundCur,
  input logic supervisionEn,
  input logic sealInEn,
  input logic cycleTick,
  input logic schemeVar,
  input logic failTrip
);
  // R1 / R2: without closed evidence the scheme term is false next clock
  assert_no_evidence_R1: assert property (@(posedge clk) disable iff (rst)
    (!phaseCur && !groundCur && !(supervisionEn && closedContact)) |=> !schemeVar);

  // R2: unsupervised contact alone never raises the term
  assert_contact_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (!supervisionEn && !phaseCur && !groundCur) |=> !schemeVar);

  // R3: without seal-in and without initiate the term drops
  assert_no_seal_R3: assert property (@(posedge clk) disable iff (rst)
    (!sealInEn && !initiate) |=> !schemeVar);

  // R4: seal-in holds the term while evidence remains
  assert_seal_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (sealInEn && schemeVar && (phaseCur || groundCur)) |=> schemeVar);

  // R7: a tick with the term false clears the trip
  assert_dropout_R7: assert property (@(posedge clk) disable iff (rst)
    (cycleTick && !schemeVar) |=> !failTrip);

  // R9: reset clears the trip
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> !failTrip);

  // R10: the trip holds between ticks
  assert_tick_only_R10: assert property (@(posedge clk) disable iff (rst)
    !cycleTick |=> $stable(failTrip));
endmodule

bind bf_detect bf_detect_checker u_checker (
  .clk          (clk),
  .rst          (rst),
  .initiate     (initiate),
  .closedContact(closedContact),
  .phaseCur     (phaseCur),
  .groundCur    (groundCur),
  .supervisionEn(supervisionEn),
  .sealInEn     (sealInEn),
  .cycleTick    (cycleTick),
  .schemeVar    (schemeVar),
  .failTrip     (failTrip)
);

// File: tb/bf_detect_bench.sv
`timescale 1ns/1ps
module bf_detect_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic initiate = 1'b0, closedContact = 1'b0, phaseCur = 1'b0, groundCur = 1'b0;
  logic supervisionEn = 1'b0, sealInEn = 1'b0, cycleTick = 1'b0;
  logic [15:0] pickupCycles = 16'd10;
  logic failTrip;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 0;

  always #5 clk = ~clk;

  bf_detect u_bf_detect (
    .clk(clk), .rst(rst), .initiate(initiate), .closedContact(closedContact),
    .phaseCur(phaseCur), .groundCur(groundCur), .supervisionEn(supervisionEn),
    .sealInEn(sealInEn), .cycleTick(cycleTick), .pickupCycles(pickupCycles),
    .failTrip(failTrip)
  );

  task automatic check(input logic actual, input logic expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One tick pulse, then an idle clock; returns sampled at a falling edge.
  task automatic tick();
    cycleTick = 1'b1;
    @(negedge clk);
    cycleTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic quiet();
    initiate = 0; closedContact = 0; phaseCur = 0; groundCur = 0;
    supervisionEn = 0; sealInEn = 0;
    idle(2);
    tick();
  endtask

  // Ticks n-1 times expecting no trip, then once more expecting trip.
  task automatic expectPickup(input int n, input string tag);
    for (int i = 0; i < n - 1; i++) begin
      tick();
      if (i == n - 2) check(failTrip, 1'b0, tag);
    end
    tick();
    check(failTrip, 1'b1, tag);
  endtask

  task automatic testReset();
    check(failTrip, 1'b0, "R9 reset state");
  endtask

  task automatic testSupervised();
    pickupCycles = 16'd10;
    supervisionEn = 1; closedContact = 1; initiate = 1;
    idle(2);
    expectPickup(11, "R1 R5 supervised contact pickup");
    quiet();
    check(failTrip, 1'b0, "R7 dropout after quiet");
  endtask

  task automatic testGround();
    groundCur = 1; initiate = 1;
    idle(2);
    expectPickup(11, "R1 ground current pickup");
    quiet();
  endtask

  task automatic testUnsupervised();
    supervisionEn = 0; closedContact = 1; initiate = 1;
    idle(2);
    for (int i = 0; i < 14; i++) tick();
    check(failTrip, 1'b0, "R2 contact ignored");
    quiet();
  endtask

  task automatic testNoSeal();
    phaseCur = 1; initiate = 1;
    idle(2);
    for (int i = 0; i < 6; i++) tick();
    initiate = 0;
    idle(2);
    for (int i = 0; i < 8; i++) tick();
    check(failTrip, 1'b0, "R3 early drop no trip");
    quiet();
  endtask

  task automatic testSealIn();
    sealInEn = 1; phaseCur = 1; initiate = 1;
    idle(2);
    for (int i = 0; i < 3; i++) tick();
    initiate = 0;
    idle(2);
    expectPickup(8, "R4 sealed pickup");
    phaseCur = 0;
    idle(3);
    check(failTrip, 1'b1, "R10 trip held until tick");
    tick();
    check(failTrip, 1'b0, "R7 R4 release on evidence loss");
    phaseCur = 1;
    idle(2);
    for (int i = 0; i < 12; i++) tick();
    check(failTrip, 1'b0, "R4 seal released stays off");
    quiet();
  endtask

  task automatic testRestart();
    phaseCur = 1; initiate = 1;
    idle(2);
    for (int i = 0; i < 6; i++) tick();
    initiate = 0;
    idle(2);
    initiate = 1;
    idle(2);
    expectPickup(11, "R8 interruption restarts pickup");
    quiet();
  endtask

  task automatic testZeroPickup();
    pickupCycles = 16'd0;
    groundCur = 1; initiate = 1;
    idle(2);
    tick();
    check(failTrip, 1'b1, "R6 zero pickup first tick");
    initiate = 0;
    idle(2);
    check(failTrip, 1'b1, "R10 hold without tick");
    tick();
    check(failTrip, 1'b0, "R7 zero pickup dropout");
    quiet();
    pickupCycles = 16'd10;
  endtask

  task automatic testResetMid();
    pickupCycles = 16'd0;
    phaseCur = 1; initiate = 1;
    idle(2);
    tick();
    check(failTrip, 1'b1, "R9 trip before reset");
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(failTrip, 1'b0, "R9 reset clears trip");
    quiet();
    pickupCycles = 16'd10;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    testReset();
    testSupervised();
    testGround();
    testUnsupervised();
    testNoSeal();
    testSealIn();
    testRestart();
    testZeroPickup();
    testResetMid();
    finishRun();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end
endmodule